// File: doc/BRIEF.md
# Dual-Style Multiplexed Host Bus Port

This block is the register-access front end of a peripheral. An 8-bit host reaches a bank of memory-mapped registers through it, over one bus that carries the address first and the data after. Two host bus styles are supported.

In the split-strobe style, an address latch enable marks the address. Separate active-low read and write strobes then move the data. In the direction-line style, an address strobe marks the address. A read/not-write level sets the direction, and an active-low data strobe times the transfer.

All host pins are asynchronous to the block clock. Each one passes through a two-flop synchronizer before any edge is detected. A small generic register file stands in for the real register contents. Its register 0 models an output-clock divider whose start-up value depends on the selected style.

The host bus has no back-pressure. Each strobe level and each address phase must be held for at least three clock cycles. Write data must stay on the bus for at least three cycles after the write strobe or data strobe rises. The block returns read data on `ad_out` while `ad_oe` is high. The pad-level tri-state buffer outside the block turns `ad_oe` into high impedance on the shared lines.

Top module: `hbus_port`

## Requirements
- R1: After reset, `ad_oe` is low and every register except register 0 reads 0x00.
- R2: With `bus_style` high at start-up, the address on `ad_in` is captured when `ale_as` falls. A write commits when `wr_n_ds` rises while `cs_n` is low. A read is served while `rd_n_rw` is low.
- R3: With `bus_style` low at start-up, the address is captured when `ale_as` falls. A write commits when `wr_n_ds` (data strobe) rises with `rd_n_rw` low. A read is served while `wr_n_ds` is low with `rd_n_rw` high.
- R4: `ad_oe` is high only while chip select is low and a read qualifier is active. It returns low within three cycles after the read strobe is released. It stays low for a read strobe given with `cs_n` high.
- R5: A write strobe given while `cs_n` is high leaves the registers unchanged.
- R6: Any write that completes within `GUARD_CYC` (default 16) cycles after reset release is discarded.
- R7: The style and the register 0 default are taken from `bus_style` during the start-up window. The default is 0x01 for a high level and 0x06 for a low level. Later changes of `bus_style` alter neither the bus style nor register 0.
- R8: A write to an address at or above `NREG` (default 8) changes no register. A read of such an address returns 0x00 with `ad_oe` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_style | input | 1 | 1: split strobes, 0: direction line plus data strobe |
| cs_n | input | 1 | Active-low chip select |
| ale_as | input | 1 | Address latch enable / address strobe; the address is taken on its falling edge |
| rd_n_rw | input | 1 | Read strobe (active low) / read-not-write level |
| wr_n_ds | input | 1 | Write strobe (active low) / data strobe (active low) |
| ad_in | input | DW | Multiplexed address/data from the bus |
| ad_out | output | DW | Read data toward the bus |
| ad_oe | output | 1 | Bus drive enable |

## Verification
A wrong latched address shows up at the next read: the data on `ad_out` comes from another register, or reads 0x00 for an out-of-range address. A wrong start-up style latch shows up at once. Register 0 reads the other default, and the direction-line strobes no longer move data. An error in the drive-enable logic is visible within three cycles of a strobe change, because `ad_oe` is checked both mid-read and after release. A broken guard window or a broken chip-select gate shows up as a changed value at the next read-back.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic {
    BUS_RWDS  = 1'b0,
    BUS_SPLIT = 1'b1
  } bus_style_e;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RSTV = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RSTV;
      q  <= RSTV;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/hbus_guard.sv
module hbus_guard #(
  parameter int CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic busy
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= CW'(CYC);
    else if (cnt != 0) cnt <= cnt - 1'b1;
  end
  assign busy = (cnt != 0);
endmodule

// File: rtl/hbus_ctrl.sv
module hbus_ctrl
  import hbus_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bus_style_e    style,
  input  logic          cs_s,
  input  logic          ale_s,
  input  logic          pa_s,
  input  logic          pb_s,
  input  logic [DW-1:0] dat_s,
  input  logic          wr_block,
  output logic          wr_en,
  output logic [DW-1:0] addr,
  output logic [DW-1:0] wr_data,
  output logic          oe
);
  logic ale_q, pb_q;
  logic addr_fall, pb_rise, wr_dir, rd_qual;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q <= 1'b0;
      pb_q  <= 1'b1;
    end else begin
      ale_q <= ale_s;
      pb_q  <= pb_s;
    end
  end

  assign addr_fall = ale_q & ~ale_s;
  assign pb_rise   = ~pb_q & pb_s;

  always_comb begin
    if (style == BUS_SPLIT) begin
      wr_dir  = 1'b1;
      rd_qual = ~pa_s;
    end else begin
      wr_dir  = ~pa_s;
      rd_qual = ~pb_s & pa_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr    <= '0;
      wr_en   <= 1'b0;
      wr_data <= '0;
    end else begin
      if (addr_fall) addr <= dat_s;
      wr_en   <= pb_rise & wr_dir & ~cs_s & ~wr_block;
      wr_data <= dat_s;
    end
  end

  assign oe = ~cs_s & rd_qual;

  // R2
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
endmodule

// File: rtl/hbus_regfile.sv
module hbus_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic [DW-1:0] init_val,
  input  logic          wr_en,
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
  logic [NREG-1:0][DW-1:0] mem;
  logic in_range;

  assign in_range = (addr < DW'(NREG));

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (i == 0 && init)
        mem[i] <= init_val;
      else if (wr_en && in_range && addr[IW-1:0] == IW'(i))
        mem[i] <= wr_data;
    end
  end

  assign rd_data = in_range ? mem[addr[IW-1:0]] : '0;

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !init) |=> $stable(mem));
  // R8
  out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_range && !init) |=> $stable(mem));
endmodule

// File: rtl/hbus_port.sv
module hbus_port
  import hbus_pkg::*;
#(
  parameter int DW = 8,
  parameter int NREG = 8,
  parameter int GUARD_CYC = 16,
  parameter logic [DW-1:0] DIV_DEF_SPLIT = 8'h01,
  parameter logic [DW-1:0] DIV_DEF_RWDS  = 8'h06
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_style,
  input  logic          cs_n,
  input  logic          ale_as,
  input  logic          rd_n_rw,
  input  logic          wr_n_ds,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe
);
  localparam int SW = DW + 4;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b0, 1'b1, 1'b1, {DW{1'b0}}};

  logic [SW-1:0] sync_q;
  logic          guard_busy, wr_en;
  logic [DW-1:0] addr, wr_data, rd_data;
  bus_style_e    style_q;

  hbus_sync #(.W(SW), .RSTV(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n, ale_as, rd_n_rw, wr_n_ds, ad_in}),
    .q(sync_q)
  );

  hbus_guard #(.CYC(GUARD_CYC)) u_guard (
    .clk(clk), .rst_n(rst_n), .busy(guard_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          style_q <= BUS_SPLIT;
    else if (guard_busy) style_q <= bus_style_e'(bus_style);
  end

  hbus_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .style(style_q),
    .cs_s(sync_q[DW+3]), .ale_s(sync_q[DW+2]),
    .pa_s(sync_q[DW+1]), .pb_s(sync_q[DW]),
    .dat_s(sync_q[DW-1:0]), .wr_block(guard_busy),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .oe(ad_oe)
  );

  hbus_regfile #(.NREG(NREG), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .init(guard_busy),
    .init_val(bus_style ? DIV_DEF_SPLIT : DIV_DEF_RWDS),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  assign ad_out = ad_oe ? rd_data : '0;

  // R4
  oe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !$past(cs_n, 2));
  // R7
  style_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !guard_busy |=> $stable(style_q));
  // R6
  guard_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    guard_busy |-> !wr_en);
endmodule

// File: tb/sim_hbus_port.sv
module sim_hbus_port;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, bus_style, cs_n, ale_as, rd_n_rw, wr_n_ds, ad_oe;
  logic [7:0] ad_in, ad_out;
  int checks = 0, fails = 0;
  bit done = 0;

  hbus_port u0 (.clk(clk), .rst_n(rst_n), .bus_style(bus_style), .cs_n(cs_n),
    .ale_as(ale_as), .rd_n_rw(rd_n_rw), .wr_n_ds(wr_n_ds), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe));

  // {is_write, addr, data/expected}
  localparam logic [16:0] VEC [8] = '{
    {1'b1, 8'h01, 8'hA5}, {1'b1, 8'h02, 8'h3C}, {1'b0, 8'h01, 8'hA5},
    {1'b0, 8'h02, 8'h3C}, {1'b1, 8'h07, 8'hFF}, {1'b0, 8'h07, 8'hFF},
    {1'b1, 8'h01, 8'h00}, {1'b0, 8'h01, 8'h00}};

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic st);
    rst_n = 0; bus_style = st; cs_n = 1; ale_as = 0;
    rd_n_rw = 1; wr_n_ds = 1; ad_in = 0;
    idle(3);
    rst_n = 1;
  endtask

  task automatic addr_phase(logic [7:0] a);
    ad_in = a; ale_as = 1; idle(3);
    ale_as = 0; idle(3);
  endtask

  task automatic host_write(logic st, logic [7:0] a, logic [7:0] d, logic cs);
    cs_n = cs;
    addr_phase(a);
    ad_in = d;
    if (st == 1'b0) rd_n_rw = 0;
    wr_n_ds = 0; idle(4);
    wr_n_ds = 1; idle(4);
    rd_n_rw = 1; cs_n = 1; idle(2);
  endtask

  task automatic host_read(logic st, logic [7:0] a, logic cs,
                           output logic [7:0] d, output logic oe_mid,
                           output logic oe_end);
    cs_n = cs;
    addr_phase(a);
    ad_in = 0;
    if (st) rd_n_rw = 0; else wr_n_ds = 0;
    idle(5);
    d = ad_out; oe_mid = ad_oe;
    rd_n_rw = 1; wr_n_ds = 1; idle(3);
    oe_end = ad_oe;
    cs_n = 1; idle(2);
  endtask

  task automatic run_table(logic st, string req);
    logic [7:0] d;
    logic om, oe2;
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][16]) host_write(st, VEC[i][15:8], VEC[i][7:0], 1'b0);
      else begin
        host_read(st, VEC[i][15:8], 1'b0, d, om, oe2);
        chk(req, d, VEC[i][7:0]);
      end
    end
  endtask

  initial begin
    logic [7:0] d;
    logic om, oe2;
    do_reset(1'b1);
    idle(1);
    // R1 reset state
    chk("R1 oe after reset", {7'b0, ad_oe}, 8'h00);
    // R6 write inside start-up window is dropped
    host_write(1'b1, 8'h03, 8'h77, 1'b0);
    idle(10);
    host_read(1'b1, 8'h03, 1'b0, d, om, oe2);
    chk("R6 guarded write", d, 8'h00);
    host_read(1'b1, 8'h05, 1'b0, d, om, oe2);
    chk("R1 reg5 reset value", d, 8'h00);
    // R4 drive enable during and after a read
    chk("R4 oe mid read", {7'b0, om}, 8'h01);
    chk("R4 oe after release", {7'b0, oe2}, 8'h00);
    // R7 split-style default
    host_read(1'b1, 8'h00, 1'b0, d, om, oe2);
    chk("R7 default split", d, 8'h01);
    // R2 table in split style
    run_table(1'b1, "R2 split table");
    // R5 write with chip select high
    host_write(1'b1, 8'h02, 8'h99, 1'b1);
    host_read(1'b1, 8'h02, 1'b0, d, om, oe2);
    chk("R5 cs high write", d, 8'h3C);
    // R4 read with chip select high
    host_read(1'b1, 8'h02, 1'b1, d, om, oe2);
    chk("R4 oe with cs high", {7'b0, om}, 8'h00);
    // R8 out-of-range access
    host_write(1'b1, 8'h09, 8'h55, 1'b0);
    host_read(1'b1, 8'h09, 1'b0, d, om, oe2);
    chk("R8 out of range data", d, 8'h00);
    chk("R8 out of range oe", {7'b0, om}, 8'h01);
    host_read(1'b1, 8'h01, 1'b0, d, om, oe2);
    chk("R8 alias untouched", d, 8'h00);
    // R7 mode pin change after start-up is ignored
    bus_style = 1'b0;
    host_write(1'b1, 8'h04, 8'h5A, 1'b0);
    host_read(1'b1, 8'h04, 1'b0, d, om, oe2);
    chk("R7 style frozen", d, 8'h5A);
    host_read(1'b1, 8'h00, 1'b0, d, om, oe2);
    chk("R7 default frozen", d, 8'h01);

    // direction-line style
    do_reset(1'b0);
    idle(20);
    host_read(1'b0, 8'h00, 1'b0, d, om, oe2);
    chk("R7 default rwds", d, 8'h06);
    chk("R4 oe after ds release", {7'b0, oe2}, 8'h00);
    run_table(1'b0, "R3 rwds table");
    host_write(1'b0, 8'h06, 8'hC3, 1'b1);
    host_read(1'b0, 8'h06, 1'b0, d, om, oe2);
    chk("R5 cs high write rwds", d, 8'h00);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all R) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule